// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block collects interrupt requests from a set of peripherals and presents a single interrupt line to one processor. While any request input is high, the processor interrupt output is high. When the processor answers with a rising acknowledge, the arbiter picks one requesting peripheral by fixed priority and raises only that peripheral's acknowledge line. The granted peripheral then puts its own vector on the shared bus. The arbiter never drives the vector itself.

The handshake has two phases. The interrupt is raised first. The winner is chosen only at the moment the processor acknowledge rises. That choice is latched and held for as long as the processor keeps its acknowledge high, whatever the requests do in the meantime. All outputs are registered and a synchronous, active-high reset clears them. The number of peripherals is a parameter (default 4), and index 0 has the highest priority.

Top module: `vectored_irq_arbiter`

## Requirements
- R1: `cpu_irq_o` in each cycle equals the OR of all bits of `req_i` sampled at the previous rising clock edge.
- R2: When `cpu_ack_i` is sampled high at an edge after being low at the edge before, and `req_i` is non-zero at that edge, `grant_o` becomes a one-hot vector after that edge. Bit k of `grant_o` belongs to peripheral k.
- R3: The bit chosen for R2 is the lowest-numbered set bit of `req_i` at that edge, so index 0 has the highest priority.
- R4: While `cpu_ack_i` stays high after its rising edge, `grant_o` keeps its latched value, even if `req_i` changes.
- R5: At the first edge where `cpu_ack_i` is sampled low, `grant_o` goes to all zeros.
- R6: At most one bit of `grant_o` is ever high.
- R7: If `req_i` is zero at the rising edge of `cpu_ack_i`, `grant_o` stays zero until `cpu_ack_i` has been sampled low again, even if requests arrive in the meantime.
- R8: While `rst` is sampled high, `cpu_irq_o` and `grant_o` are cleared to zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Request lines, one per peripheral, bit 0 highest priority |
| cpu_ack_i | input | 1 | Acknowledge returned by the processor |
| cpu_irq_o | output | 1 | Interrupt line to the processor |
| grant_o | output | NUM_SRC | Acknowledge lines to the peripherals, at most one high |

## Verification
Two events can share one clock edge: a change of the request pattern and the rising edge of the processor acknowledge. The winner must then come from the requests present at that same edge, not from those of the cycle before. The bench provokes this by changing `req_i` in the same cycle that `cpu_ack_i` rises, both from no requests and from a different pattern. It also drops and raises the acknowledge on consecutive edges, and runs a stretch of random stimulus. A behavioural model decides the expected grant and interrupt for every cycle, and these are compared with the outputs.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

    // handshake phase of the grant sequencer
    typedef enum logic {
        PH_IDLE = 1'b0,   // waiting for a processor acknowledge edge
        PH_HOLD = 1'b1    // decision latched, held until acknowledge drops
    } vpa_phase_e;

endpackage

// File: rtl/vpa_prio_pick.sv
// Fixed-priority picker: the lowest set index wins.
module vpa_prio_pick #(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] onehot,
    output logic               any
);
    localparam int CHAIN_W = NUM_SRC + 1;

    // seen[i] is set when some index below i is requesting
    logic [CHAIN_W-1:0] seen;

    assign seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_stage
            assign onehot[gi]  = req[gi] & ~seen[gi];
            assign seen[gi+1]  = seen[gi] | req[gi];
        end
    endgenerate

    assign any = seen[NUM_SRC];

endmodule

// File: rtl/vpa_ack_seq.sv
// Grant sequencer: latches the picked winner on the rising edge of the
// processor acknowledge and holds it until that acknowledge drops.
module vpa_ack_seq
    import vpa_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_ack,
    input  logic [NUM_SRC-1:0] pick_onehot,
    input  logic               pick_any,
    output logic [NUM_SRC-1:0] grant
);
    typedef struct packed {
        vpa_phase_e         phase;
        logic               ack_prev;
        logic [NUM_SRC-1:0] grant;
    } seq_state_t;

    seq_state_t st_q, st_d;
    logic       ack_rise;

    always_comb begin
        ack_rise       = cpu_ack & ~st_q.ack_prev;
        st_d           = st_q;
        st_d.ack_prev  = cpu_ack;
        unique case (st_q.phase)
            PH_IDLE: begin
                st_d.grant = '0;
                if (ack_rise) begin
                    // an empty request set still enters the hold phase
                    st_d.grant = pick_any ? pick_onehot : '0;
                    st_d.phase = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (!cpu_ack) begin
                    st_d.grant = '0;
                    st_d.phase = PH_IDLE;
                end
            end
            default: begin
                st_d.grant = '0;
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase    <= PH_IDLE;
            st_q.ack_prev <= 1'b0;
            st_q.grant    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant = st_q.grant;

endmodule

// File: rtl/vectored_irq_arbiter.sv
module vectored_irq_arbiter #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               cpu_ack_i,
    output logic               cpu_irq_o,
    output logic [NUM_SRC-1:0] grant_o
);
    typedef struct packed {
        logic irq;
    } top_state_t;

    top_state_t         top_q, top_d;
    logic [NUM_SRC-1:0] pick_onehot;
    logic               pick_any;

    vpa_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req    (req_i),
        .onehot (pick_onehot),
        .any    (pick_any)
    );

    vpa_ack_seq #(.NUM_SRC(NUM_SRC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cpu_ack     (cpu_ack_i),
        .pick_onehot (pick_onehot),
        .pick_any    (pick_any),
        .grant       (grant_o)
    );

    always_comb begin
        top_d     = top_q;
        top_d.irq = pick_any;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q.irq <= 1'b0;
        end else begin
            top_q <= top_d;
        end
    end

    assign cpu_irq_o = top_q.irq;

endmodule

// File: rtl/vpa_arb_chk.sv
module vpa_arb_chk #(
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] req_i,
    input logic               cpu_ack_i,
    input logic               cpu_irq_o,
    input logic [NUM_SRC-1:0] grant_o
);
    // set once a clock edge has passed outside reset
    logic live_q;

    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    // R1
    irq_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cpu_irq_o == (|$past(req_i))));

    // R2
    grant_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && cpu_ack_i && !$past(cpu_ack_i) && (req_i != '0))
        |=> (grant_o == ($past(req_i) & (~$past(req_i) + 1'b1))));

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && cpu_ack_i && $past(cpu_ack_i)) |=> $stable(grant_o));

    // R5
    grant_release_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_ack_i |=> (grant_o == '0));

    // R6
    grant_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R7
    empty_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && cpu_ack_i && !$past(cpu_ack_i) && (req_i == '0))
        |=> (grant_o == '0));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> ((grant_o == '0) && !cpu_irq_o));

endmodule

bind vectored_irq_arbiter vpa_arb_chk #(.NUM_SRC(NUM_SRC)) u_arb_chk (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .cpu_ack_i (cpu_ack_i),
    .cpu_irq_o (cpu_irq_o),
    .grant_o   (grant_o)
);

// File: tb/tb_vectored_irq_arbiter.sv
`timescale 1ns/1ps
module tb_vectored_irq_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_i = '0;
    logic         cpu_ack_i = 1'b0;
    logic         cpu_irq_o;
    logic [N-1:0] grant_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference
    bit         m_irq;
    bit [N-1:0] m_grant;
    bit         m_prev;
    string      cur_tag = "R8";

    always #2 clk = ~clk;   // 250 MHz

    vectored_irq_arbiter #(.NUM_SRC(N)) dut (
        .clk(clk), .rst(rst), .req_i(req_i), .cpu_ack_i(cpu_ack_i),
        .cpu_irq_o(cpu_irq_o), .grant_o(grant_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_irq = 0; m_grant = '0; m_prev = 0;
        end else begin
            m_irq = (req_i != '0);
            if (cpu_ack_i && !m_prev) begin
                m_grant = '0;
                for (int i = 0; i < N; i++) begin
                    if (req_i[i] && m_grant == '0) m_grant[i] = 1'b1;
                end
            end else if (!cpu_ack_i) begin
                m_grant = '0;
            end
            m_prev = cpu_ack_i;
        end
    end

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // compare at the falling edge, then apply the next inputs
    task automatic step(logic [N-1:0] r, logic a, string tag);
        @(negedge clk);
        check({cur_tag, " irq (R1)"}, {{(N-1){1'b0}}, cpu_irq_o}, {{(N-1){1'b0}}, m_irq});
        check({cur_tag, " grant"}, grant_o, m_grant);
        tests++;
        if ($countones(grant_o) > 1) begin
            fails++;
            $display("FAIL R6: actual %b expected at most one bit", grant_o);
        end
        req_i = r; cpu_ack_i = a; cur_tag = tag;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        // R8: reset with active inputs
        req_i = '1; cpu_ack_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 reset grant", grant_o, '0);
        check("R8 reset irq", {{(N-1){1'b0}}, cpu_irq_o}, '0);
        req_i = '0; cpu_ack_i = 1'b0; rst = 1'b0;

        // R1: interrupt follows requests
        step(4'b0000, 0, "R1");
        step(4'b1000, 0, "R1");
        step(4'b0100, 0, "R1");
        step(4'b0000, 0, "R1");
        step(4'b0000, 0, "R1");

        // R2 R3: two requesters, lower index wins
        step(4'b1010, 0, "R1");
        step(4'b1010, 1, "R3");
        // R4: requests change while held
        step(4'b0001, 1, "R4");
        step(4'b0000, 1, "R4");
        step(4'b1111, 1, "R4");
        // R5: release
        step(4'b1111, 0, "R5");
        step(4'b1111, 0, "R5");
        // R3: full set, index 0 wins
        step(4'b1111, 1, "R3");
        step(4'b1111, 1, "R4");
        step(4'b1000, 0, "R5");
        // R2: only top index
        step(4'b1000, 1, "R2");
        step(4'b1000, 1, "R4");
        step(4'b0000, 0, "R5");
        step(4'b0000, 0, "R5");

        // R7: empty acknowledge, requests arrive while held
        step(4'b0000, 1, "R7");
        step(4'b0010, 1, "R7");
        step(4'b0110, 1, "R7");
        step(4'b0110, 0, "R7");
        step(4'b0000, 0, "R5");

        // R2: request and acknowledge rise in the same cycle
        step(4'b0100, 1, "R2");
        step(4'b0100, 1, "R4");
        // pattern change coinciding with a fresh acknowledge edge
        step(4'b0100, 0, "R5");
        step(4'b1001, 1, "R3");
        step(4'b1001, 1, "R4");
        // back-to-back: drop then rise again
        step(4'b0110, 0, "R5");
        step(4'b0110, 1, "R3");
        step(4'b0110, 1, "R4");
        step(4'b0000, 0, "R5");

        // random stretch
        for (int k = 0; k < 400; k++) begin
            step(N'($urandom_range(0, 15)), 1'($urandom_range(0, 2) != 0), "R6");
        end
        step(4'b0000, 0, "R5");
        step(4'b0000, 0, "R5");

        finish_run();
    end

endmodule